// File: doc/BRIEF.md
# Framebuffer Span Copy Engine

This block carries out one span-copy command that already sits in a local command buffer of 32-bit words. On a start pulse it checks that word 0 holds the copy opcode, takes the number of spans from the top byte of word 1, and then walks a packed list of three-word span records beginning at word 5. Each record gives a length, a source row and a destination row, all in fixed point with three fraction bits. For every span the engine moves pixels one at a time from the start of the source row to the same columns of the destination row through a single framebuffer port. It then widens a dirty rectangle that a display refresh can consume.

The command buffer is read through a combinational word port: the engine drives a word index and sees the word in the same cycle. The framebuffer port has one shared address, a read enable with one cycle of read latency, and a write enable. Rows are 1280 pixels wide, so a pixel lives at row × 1280 + column. The pixel width in bytes is a parameter.

The controller is a state machine. The states are IDLE, HEAD, LEN, SRC, DST, READ, WRITE, MARK and DONE. IDLE moves to HEAD on start when the opcode matches. HEAD moves to DONE when the span count is zero and to LEN otherwise. LEN moves to SRC, and SRC moves to DST. DST moves to MARK for a zero-length span and to READ otherwise. READ always moves to WRITE. WRITE returns to READ until the last column of the span and then moves to MARK. MARK returns to LEN while spans remain and moves to DONE after the last one. DONE always returns to IDLE.

Top module: `span_copy_engine`

## Requirements
- R1: A start pulse seen in IDLE is accepted only when command word 0 equals 0x00000405 exactly. Any other value leaves the engine idle, with busy and done low, no framebuffer access and the dirty outputs unchanged. Start pulses while the engine is busy are ignored.
- R2: The span count is bits 31:24 of command word 1, and the other 24 bits are ignored. Span record i occupies words 5+3i, 6+3i and 7+3i, in the order length, source row, destination row, so a command spans 5 + 3·count words.
- R3: Each record field is shifted right by 3 before use. A row is the low 10 bits of the shifted value.
- R4: A shifted length larger than 1280 is clamped to 1280.
- R5: A span of length L copies columns 0 to L-1 in ascending order. Each pixel takes a read at src·1280+col followed, in the next cycle, by a write at dst·1280+col of the data returned by that read. Read data arrives one cycle after the read enable.
- R6: After each span, dirty_any is 1, the dirty columns are 0 to 1279, and the dirty row range is widened to include both the source and destination rows. An accepted start clears all dirty outputs to 0.
- R7: busy is high from the cycle after an accepted start until the last span is finished. Its length in cycles is 1 + Σ(4 + 2·L). done is then high for exactly one cycle with busy low.
- R8: A span count of zero gives one busy cycle, then done, with no framebuffer access and dirty_any left at 0.
- R9: A span of length zero makes no framebuffer access but still widens the dirty rows.
- R10: The read and write enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the command in the buffer |
| cmd_addr | output | CMD_AW (10) | Command buffer word index |
| cmd_data | input | 32 | Command word at cmd_addr, same cycle |
| fb_addr | output | FB_AW (21) | Framebuffer pixel address |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_rd_data | input | 8·PIX_BYTES | Read data, one cycle after fb_rd_en |
| fb_wr_en | output | 1 | Framebuffer write strobe |
| fb_wr_data | output | 8·PIX_BYTES | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dirty_any | output | 1 | Dirty region holds at least one span |
| dirty_row_lo | output | ROW_W (10) | Lowest dirty row |
| dirty_row_hi | output | ROW_W (10) | Highest dirty row |
| dirty_col_lo | output | COL_W (11) | Lowest dirty column |
| dirty_col_hi | output | COL_W (11) | Highest dirty column |

## Verification
The engine is driven with these command patterns:
- Wrong opcodes, including one that differs from the copy opcode only in a high bit. These show that the opcode match is exact.
- A zero span count with junk in the low header bits. This shows that the count comes from the top byte alone.
- A single plain span, which fixes the address arithmetic and the read-to-write data path.
- A mixed list holding a span copied onto its own row, a zero-length span, fraction bits and a row value with high bits set. This list shows that the fraction bits are dropped, that rows are truncated and that the dirty range widens correctly.
- Two full-row spans with oversized length words that copy in opposite directions. These show the clamp and the order in which pixels are updated.

A start pulse in the middle of a run shows that requests made while busy are ignored.

// File: rtl/span_copy_pkg.sv
package span_copy_pkg;

    localparam logic [31:0] SPAN_COPY_OP = 32'h0000_0405;
    localparam int          HDR_WORDS    = 5;
    localparam int          FRAC_BITS    = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_LEN,
        ST_SRC,
        ST_DST,
        ST_READ,
        ST_WRITE,
        ST_MARK,
        ST_DONE
    } sc_state_e;

endpackage

// File: rtl/span_fixp_decode.sv
module span_fixp_decode #(
    parameter int OUT_W = 11,
    parameter int FRAC  = 3,
    parameter int CLAMP = 0
) (
    input  logic [31:0]      raw,
    output logic [OUT_W-1:0] val
);
    logic [31:0] shifted;
    assign shifted = raw >> FRAC;

    generate
        if (CLAMP > 0) begin : g_clamp
            assign val = (shifted > 32'(CLAMP)) ? OUT_W'(CLAMP) : shifted[OUT_W-1:0];
        end else begin : g_trunc
            logic unused_hi;
            assign unused_hi = ^shifted[31:OUT_W];
            assign val = shifted[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/span_addr_gen.sv
module span_addr_gen #(
    parameter int ROW_PIX = 1280,
    parameter int ROW_W   = 10,
    parameter int COL_W   = 11,
    parameter int AW      = 21
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [AW-1:0]    addr
);
    localparam bit POW2 = ((ROW_PIX & (ROW_PIX - 1)) == 0);

    generate
        if (POW2) begin : g_shift
            assign addr = (AW'(row) << $clog2(ROW_PIX)) | AW'(col);
        end else begin : g_mult
            assign addr = AW'(row) * AW'(ROW_PIX) + AW'(col);
        end
    endgenerate
endmodule

// File: rtl/span_dirty_track.sv
module span_dirty_track #(
    parameter int ROW_W   = 10,
    parameter int COL_W   = 11,
    parameter int ROW_PIX = 1280
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [ROW_W-1:0] row_a,
    input  logic [ROW_W-1:0] row_b,
    output logic             any,
    output logic [ROW_W-1:0] lo,
    output logic [ROW_W-1:0] hi,
    output logic [COL_W-1:0] col_lo,
    output logic [COL_W-1:0] col_hi
);
    logic [ROW_W-1:0] pair_lo, pair_hi;

    assign pair_lo = (row_a < row_b) ? row_a : row_b;
    assign pair_hi = (row_a < row_b) ? row_b : row_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any    <= 1'b0;
            lo     <= '0;
            hi     <= '0;
            col_lo <= '0;
            col_hi <= '0;
        end else if (clr) begin
            any    <= 1'b0;
            lo     <= '0;
            hi     <= '0;
            col_lo <= '0;
            col_hi <= '0;
        end else if (upd) begin
            any    <= 1'b1;
            lo     <= (!any || pair_lo < lo) ? pair_lo : lo;
            hi     <= (!any || pair_hi > hi) ? pair_hi : hi;
            col_lo <= '0;
            col_hi <= COL_W'(ROW_PIX - 1);
        end
    end
endmodule

// File: rtl/span_copy_engine.sv
module span_copy_engine
    import span_copy_pkg::*;
#(
    parameter  int PIX_BYTES = 1,
    parameter  int ROW_PIX   = 1280,
    parameter  int ROW_W     = 10,
    parameter  int CMD_AW    = 10,
    localparam int DW        = 8 * PIX_BYTES,
    localparam int COL_W     = $clog2(ROW_PIX),
    localparam int LEN_W     = $clog2(ROW_PIX + 1),
    localparam int FB_WORDS  = (2 ** ROW_W) * ROW_PIX,
    localparam int FB_AW     = $clog2(FB_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [CMD_AW-1:0] cmd_addr,
    input  logic [31:0]       cmd_data,
    output logic [FB_AW-1:0]  fb_addr,
    output logic              fb_rd_en,
    input  logic [DW-1:0]     fb_rd_data,
    output logic              fb_wr_en,
    output logic [DW-1:0]     fb_wr_data,
    output logic              busy,
    output logic              done,
    output logic              dirty_any,
    output logic [ROW_W-1:0]  dirty_row_lo,
    output logic [ROW_W-1:0]  dirty_row_hi,
    output logic [COL_W-1:0]  dirty_col_lo,
    output logic [COL_W-1:0]  dirty_col_hi
);
    sc_state_e state, state_nx;

    logic [7:0]        span_cnt, span_idx;
    logic [CMD_AW-1:0] ptr;
    logic [LEN_W-1:0]  len_q, col_q, len_dec;
    logic [ROW_W-1:0]  src_q, dst_q, row_dec, fb_row;
    logic              accept, last_col, last_span;

    assign accept    = (state == ST_IDLE) && start && (cmd_data == SPAN_COPY_OP);
    assign last_col  = (col_q + 1'b1) == len_q;
    assign last_span = ({1'b0, span_idx} + 9'd1) == {1'b0, span_cnt};

    span_fixp_decode #(.OUT_W(LEN_W), .FRAC(FRAC_BITS), .CLAMP(ROW_PIX)) u_len_dec (
        .raw(cmd_data), .val(len_dec)
    );

    span_fixp_decode #(.OUT_W(ROW_W), .FRAC(FRAC_BITS), .CLAMP(0)) u_row_dec (
        .raw(cmd_data), .val(row_dec)
    );

    assign fb_row = (state == ST_WRITE) ? dst_q : src_q;

    span_addr_gen #(.ROW_PIX(ROW_PIX), .ROW_W(ROW_W), .COL_W(COL_W), .AW(FB_AW)) u_addr (
        .row(fb_row), .col(col_q[COL_W-1:0]), .addr(fb_addr)
    );

    span_dirty_track #(.ROW_W(ROW_W), .COL_W(COL_W), .ROW_PIX(ROW_PIX)) u_dirty (
        .clk(clk), .rst_n(rst_n),
        .clr(accept), .upd(state == ST_MARK),
        .row_a(src_q), .row_b(dst_q),
        .any(dirty_any), .lo(dirty_row_lo), .hi(dirty_row_hi),
        .col_lo(dirty_col_lo), .col_hi(dirty_col_hi)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_HEAD;
            ST_HEAD:  state_nx = (cmd_data[31:24] == 8'd0) ? ST_DONE : ST_LEN;
            ST_LEN:   state_nx = ST_SRC;
            ST_SRC:   state_nx = ST_DST;
            ST_DST:   state_nx = (len_q == '0) ? ST_MARK : ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = last_col ? ST_MARK : ST_READ;
            ST_MARK:  state_nx = last_span ? ST_DONE : ST_LEN;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // span datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_cnt <= '0;
            span_idx <= '0;
            ptr      <= '0;
            len_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            col_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    ptr      <= CMD_AW'(HDR_WORDS);
                    span_idx <= '0;
                end
                ST_HEAD:  span_cnt <= cmd_data[31:24];
                ST_LEN: begin
                    len_q <= len_dec;
                    ptr   <= ptr + 1'b1;
                end
                ST_SRC: begin
                    src_q <= row_dec;
                    ptr   <= ptr + 1'b1;
                end
                ST_DST: begin
                    dst_q <= row_dec;
                    ptr   <= ptr + 1'b1;
                    col_q <= '0;
                end
                ST_WRITE: col_q    <= col_q + 1'b1;
                ST_MARK:  span_idx <= span_idx + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_addr   = '0;
        fb_rd_en   = 1'b0;
        fb_wr_en   = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        fb_wr_data = fb_rd_data;
        unique case (state)
            ST_IDLE:  cmd_addr = '0;
            ST_HEAD:  begin busy = 1'b1; cmd_addr = CMD_AW'(1); end
            ST_LEN,
            ST_SRC,
            ST_DST:   begin busy = 1'b1; cmd_addr = ptr; end
            ST_READ:  begin busy = 1'b1; fb_rd_en = 1'b1; end
            ST_WRITE: begin busy = 1'b1; fb_wr_en = 1'b1; end
            ST_MARK:  busy = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/span_copy_chk.sv
module span_copy_chk #(
    parameter int AW       = 21,
    parameter int ROW_W    = 10,
    parameter int FB_WORDS = 1310720
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      cmd_data,
    input logic             busy,
    input logic             done,
    input logic             fb_rd_en,
    input logic             fb_wr_en,
    input logic [AW-1:0]    fb_addr,
    input logic             dirty_any,
    input logic [ROW_W-1:0] dirty_row_lo,
    input logic [ROW_W-1:0] dirty_row_hi
);
    // R1
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && cmd_data != 32'h0000_0405) |=> (!busy && !done));

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fb_rd_en, fb_wr_en}));

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr_en |-> $past(fb_rd_en));

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd_en || fb_wr_en) |-> (int'(fb_addr) < FB_WORDS));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R6
    dirty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_any |-> (dirty_row_lo <= dirty_row_hi));
endmodule

bind span_copy_engine span_copy_chk #(.AW(FB_AW), .ROW_W(ROW_W), .FB_WORDS(FB_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_data(cmd_data),
    .busy(busy), .done(done), .fb_rd_en(fb_rd_en), .fb_wr_en(fb_wr_en),
    .fb_addr(fb_addr), .dirty_any(dirty_any),
    .dirty_row_lo(dirty_row_lo), .dirty_row_hi(dirty_row_hi)
);

// File: tb/test_span_copy_engine.sv
`timescale 1ns/1ps
module test_span_copy_engine;
    localparam int DW    = 8;
    localparam int ROWP  = 1280;
    localparam int COL_W = 11;
    localparam int ROW_W = 10;
    localparam int AW    = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [9:0]       cmd_addr;
    logic [31:0]      cmd_data;
    logic [AW-1:0]    fb_addr;
    logic             fb_rd_en, fb_wr_en;
    logic [DW-1:0]    fb_rd_data = '0;
    logic [DW-1:0]    fb_wr_data;
    logic             busy, done, dirty_any;
    logic [ROW_W-1:0] dirty_row_lo, dirty_row_hi;
    logic [COL_W-1:0] dirty_col_lo, dirty_col_hi;

    always #2 clk = ~clk;

    logic [31:0] cbuf [0:1023];
    assign cmd_data = cbuf[cmd_addr];

    span_copy_engine i_span_copy_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .fb_addr(fb_addr), .fb_rd_en(fb_rd_en), .fb_rd_data(fb_rd_data),
        .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data),
        .busy(busy), .done(done), .dirty_any(dirty_any),
        .dirty_row_lo(dirty_row_lo), .dirty_row_hi(dirty_row_hi),
        .dirty_col_lo(dirty_col_lo), .dirty_col_hi(dirty_col_hi)
    );

    int fbm [int];
    int rm  [int];

    function automatic int seed_val(int a);
        return (a * 37 + 11) & 255;
    endfunction

    always @(posedge clk) begin
        if (fb_rd_en) fb_rd_data <= DW'(fbm.exists(int'(fb_addr)) ? fbm[int'(fb_addr)] : seed_val(int'(fb_addr)));
        if (fb_wr_en) fbm[int'(fb_addr)] = int'(fb_wr_data);
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    bit [31:0] d_len[$], d_src[$], d_dst[$];
    bit q_wr[$];
    int q_addr[$], q_dat[$];
    int e_any = 0, e_lo = 0, e_hi = 0;

    task automatic run_cmd(input bit [31:0] op, input bit [31:0] hdr, input bit mid_start, input string tag);
        bit acc;
        int n, ncyc;
        for (int i = 0; i < 1024; i++) cbuf[i] = 32'hC0DE_0000 | 32'(i);
        cbuf[0] = op;
        cbuf[1] = hdr;
        acc = (op == 32'h0000_0405);
        n = acc ? int'(hdr[31:24]) : 0;
        ncyc = acc ? 1 : 0;
        if (acc) begin e_any = 0; e_lo = 0; e_hi = 0; end
        for (int i = 0; i < n; i++) begin
            longint ln;
            int sr, ds;
            cbuf[5 + 3*i] = d_len[i];
            cbuf[6 + 3*i] = d_src[i];
            cbuf[7 + 3*i] = d_dst[i];
            ln = longint'(d_len[i] >> 3);
            if (ln > ROWP) ln = ROWP;
            sr = int'((d_src[i] >> 3) & 32'd1023);
            ds = int'((d_dst[i] >> 3) & 32'd1023);
            for (int c = 0; c < int'(ln); c++) begin
                int sa, da, v;
                sa = sr * ROWP + c;
                da = ds * ROWP + c;
                v  = rm.exists(sa) ? rm[sa] : seed_val(sa);
                q_wr.push_back(1'b0); q_addr.push_back(sa); q_dat.push_back(0);
                q_wr.push_back(1'b1); q_addr.push_back(da); q_dat.push_back(v);
                rm[da] = v;
            end
            ncyc += 4 + 2 * int'(ln);
            if (e_any == 0) begin
                e_lo = (sr < ds) ? sr : ds;
                e_hi = (sr < ds) ? ds : sr;
            end else begin
                if (sr < e_lo) e_lo = sr;
                if (ds < e_lo) e_lo = ds;
                if (sr > e_hi) e_hi = sr;
                if (ds > e_hi) e_hi = ds;
            end
            e_any = 1;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 1; k <= ncyc + 2; k++) begin
            chk({tag, " R7 busy"}, int'(busy), int'(k <= ncyc));
            chk({tag, " R7 done"}, int'(done), int'(acc && k == ncyc + 1));
            chk({tag, " R10 rd/wr overlap"}, int'(fb_rd_en && fb_wr_en), 0);
            if (fb_rd_en || fb_wr_en) begin
                if (q_wr.size() == 0) begin
                    chk({tag, " R5 unexpected access"}, 1, 0);
                end else begin
                    bit w;
                    int a, dt;
                    w = q_wr.pop_front(); a = q_addr.pop_front(); dt = q_dat.pop_front();
                    chk({tag, " R5 access kind"}, int'(fb_wr_en), int'(w));
                    chk({tag, " R5 address"}, int'(fb_addr), a);
                    if (w) chk({tag, " R5 write data"}, int'(fb_wr_data), dt);
                end
            end
            start = (mid_start && k == 3);
            @(negedge clk);
        end
        chk({tag, " R5 missing accesses"}, q_wr.size(), 0);
        q_wr.delete(); q_addr.delete(); q_dat.delete();
        chk({tag, " R6 dirty_any"}, int'(dirty_any), e_any);
        chk({tag, " R6 row lo"}, int'(dirty_row_lo), e_lo);
        chk({tag, " R6 row hi"}, int'(dirty_row_hi), e_hi);
        chk({tag, " R6 col lo"}, int'(dirty_col_lo), 0);
        chk({tag, " R6 col hi"}, int'(dirty_col_hi), e_any ? ROWP - 1 : 0);
        d_len.delete(); d_src.delete(); d_dst.delete();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) cbuf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset R7 busy", int'(busy), 0);
        chk("reset R7 done", int'(done), 0);
        chk("reset R10 rd", int'(fb_rd_en), 0);
        chk("reset R10 wr", int'(fb_wr_en), 0);
        chk("reset R6 dirty_any", int'(dirty_any), 0);

        // R1: wrong opcodes rejected
        run_cmd(32'h0000_0404, 32'h0100_0000, 0, "R1 op404");
        run_cmd(32'h0001_0405, 32'h0100_0000, 0, "R1 op10405");

        // R8, R2: zero count, junk in header low bits
        run_cmd(32'h0000_0405, 32'h00FF_FFFF, 0, "R8 zero");

        // R2, R5: single span
        d_len.push_back(32'd4 << 3); d_src.push_back(32'd2 << 3); d_dst.push_back(32'd7 << 3);
        run_cmd(32'h0000_0405, 32'h01AB_CDEF, 0, "R2 single");

        // R3, R9, R1 (mid start): mixed list
        d_len.push_back(32'h27);             d_src.push_back((32'd3 << 3) | 32'd5); d_dst.push_back(32'd3 << 3);
        d_len.push_back(32'd0);              d_src.push_back(32'd9 << 3);           d_dst.push_back(32'd1 << 3);
        d_len.push_back(32'd6 << 3);         d_src.push_back(32'd1036 << 3);        d_dst.push_back(32'd4 << 3);
        run_cmd(32'h0000_0405, 32'h0300_0012, 1, "R3 R9 mixed");

        // R4: clamp, opposite directions
        d_len.push_back(32'd2000 << 3);      d_src.push_back(32'd0);                d_dst.push_back(32'd1 << 3);
        d_len.push_back(32'hFFFF_FFF8);      d_src.push_back(32'd1 << 3);           d_dst.push_back(32'd0);
        run_cmd(32'h0000_0405, 32'h0200_0000, 0, "R4 clamp");

        // R1: rejection keeps dirty region
        run_cmd(32'h0000_0000, 32'h0100_0000, 0, "R1 keep dirty");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule